// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the memory address for one load or store operation in a 32-bit register-based core. In the same cycle it forms the value the base register should take afterwards, and it decides whether that value is written back. The offset is one of two kinds. It can be a 12-bit immediate magnitude, or it can be a register value passed through a logical shifter that moves it left or right by 0 to 31 places. A subtract select decides whether the offset is added to the base or taken away from it.

An index select picks between two forms. In the pre-indexed form the address is the base combined with the offset. In the post-indexed form the address is the untouched base. Base register index 15 names the program counter. When it is the base, the value used is the instruction address plus 8.

All results are registered. They appear together with a one-cycle valid pulse after a request. Writeback to the program counter index is never issued: an error strobe is raised in its place.

Top module: `ls_agu`

## Requirements
- R1: While reset is held and in the first cycle after it, `res_valid`, `wb_en` and `wb_err` are 0.
- R2: `res_valid` is 1 exactly in the cycle after a cycle with `req_valid` = 1. All outputs of that request appear in that same cycle.
- R3: With `post_index` = 0, `eff_addr` is the base plus or minus the offset, and `wb_en` equals `wb_req`.
- R4: With `post_index` = 0 and `wb_req` = 1, `new_base` equals `eff_addr`. This covers a push: base 2012, immediate 4, subtract, which gives 2008 on both outputs.
- R5: With `post_index` = 1, `eff_addr` is the base unchanged and `new_base` is the base plus or minus the offset. `wb_en` is 1 whatever `wb_req` is, unless R10 applies.
- R6: With `use_reg_off` = 0, the offset is `imm_off` zero-extended to 32 bits. Its sign comes only from `subtract`.
- R7: With `use_reg_off` = 1, the offset is `off_reg` shifted logically by `shift_amt` (0 to 31) places. `shift_right` = 0 shifts left and 1 shifts right. Vacated bits are filled with zeros.
- R8: `subtract` = 1 takes the offset away from the base, modulo 2^32. `subtract` = 0 adds it.
- R9: When `base_idx` = 15, the base used is `instr_addr` + 8, and `base_val` is ignored.
- R10: When `base_idx` = 15 and writeback would occur (`wb_req` = 1 or `post_index` = 1), `wb_en` is 0 and `wb_err` is 1 for that result.
- R11: `wb_idx` carries the `base_idx` of the request that produced the result.
- R12: In a cycle after no request, `wb_en` and `wb_err` are 0, and `eff_addr`, `new_base` and `wb_idx` keep the values of the last request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| base_val | input | 32 | Base register contents |
| base_idx | input | 4 | Base register index (15 = program counter) |
| use_reg_off | input | 1 | 1 = shifted register offset, 0 = immediate |
| imm_off | input | 12 | Immediate offset magnitude |
| off_reg | input | 32 | Offset register contents |
| shift_right | input | 1 | 1 = logical right shift, 0 = left |
| shift_amt | input | 5 | Shift distance |
| subtract | input | 1 | 1 = subtract offset, 0 = add |
| post_index | input | 1 | 1 = post-indexed, 0 = pre-indexed |
| wb_req | input | 1 | Writeback requested |
| instr_addr | input | 32 | Address of the current instruction |
| res_valid | output | 1 | Result valid pulse |
| eff_addr | output | 32 | Effective address |
| new_base | output | 32 | Updated base value |
| wb_en | output | 1 | Base writeback strobe |
| wb_idx | output | 4 | Register index to write back |
| wb_err | output | 1 | Writeback to program counter refused |

## Verification
Immediate offsets with add and subtract tell a sign error apart from a zero-extension error. An offset of 4095 subtracted from a base of 0 also exposes broken wraparound. Register offsets are shifted by 0, 2 and 31 places, both left and right. This separates the shift directions and catches shifter stages that are missing or swapped.

The same operands are run through pre-indexed, pre-indexed-with-writeback and post-indexed forms. This shows which sum feeds the address and which feeds the new base, and whether writeback is forced. Program-counter bases are tried with no writeback, with requested writeback and in post-indexed form. These cover the read-ahead of 8 and the refused writeback. Idle cycles carrying changing inputs confirm that the data outputs hold.

// File: rtl/agu_pkg.sv
package agu_pkg;
    localparam int AGU_XLEN   = 32;
    localparam int AGU_RIDX_W = 4;

    typedef struct packed {
        logic                  valid;
        logic [AGU_XLEN-1:0]   eff;
        logic [AGU_XLEN-1:0]   nbase;
        logic                  wb_en;
        logic                  wb_err;
        logic [AGU_RIDX_W-1:0] wb_idx;
    } agu_res_t;
endpackage

// File: rtl/agu_base_sel.sv
module agu_base_sel #(
    parameter int XLEN     = 32,
    parameter int RIDX_W   = 4,
    parameter int PC_IDX   = 15,
    parameter int PC_AHEAD = 8
) (
    input  logic [XLEN-1:0]   base_val,
    input  logic [RIDX_W-1:0] base_idx,
    input  logic [XLEN-1:0]   instr_addr,
    output logic [XLEN-1:0]   base_eff,
    output logic              is_pc
);
    always_comb begin
        is_pc    = (base_idx == RIDX_W'(PC_IDX));
        base_eff = is_pc ? (instr_addr + XLEN'(PC_AHEAD)) : base_val;
    end
endmodule

// File: rtl/agu_offset_gen.sv
module agu_offset_gen #(
    parameter int XLEN    = 32,
    parameter int IMM_W   = 12,
    parameter int SHAMT_W = 5
) (
    input  logic               use_reg,
    input  logic [IMM_W-1:0]   imm,
    input  logic [XLEN-1:0]    reg_val,
    input  logic               shift_right,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [XLEN-1:0]    offset
);
    localparam int PAD_W = XLEN - IMM_W;

    // logarithmic shifter: stage i moves by 2**i when shamt[i] is set
    logic [XLEN-1:0] stage [0:SHAMT_W];
    assign stage[0] = reg_val;

    for (genvar i = 0; i < SHAMT_W; i++) begin : g_stage
        localparam int DIST = 1 << i;
        assign stage[i+1] = !shamt[i]   ? stage[i] :
                            shift_right ? (stage[i] >> DIST) :
                                          (stage[i] << DIST);
    end

    always_comb begin
        if (use_reg) offset = stage[SHAMT_W];
        else         offset = {{PAD_W{1'b0}}, imm};
    end
endmodule

// File: rtl/agu_addsub.sv
module agu_addsub #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            sub,
    output logic [XLEN-1:0] y
);
    always_comb begin
        y = sub ? (a - b) : (a + b);
    end
endmodule

// File: rtl/ls_agu.sv
module ls_agu
    import agu_pkg::*;
#(
    parameter int XLEN     = AGU_XLEN,
    parameter int RIDX_W   = AGU_RIDX_W,
    parameter int IMM_W    = 12,
    parameter int SHAMT_W  = 5,
    parameter int PC_IDX   = 15,
    parameter int PC_AHEAD = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [XLEN-1:0]    base_val,
    input  logic [RIDX_W-1:0]  base_idx,
    input  logic               use_reg_off,
    input  logic [IMM_W-1:0]   imm_off,
    input  logic [XLEN-1:0]    off_reg,
    input  logic               shift_right,
    input  logic [SHAMT_W-1:0] shift_amt,
    input  logic               subtract,
    input  logic               post_index,
    input  logic               wb_req,
    input  logic [XLEN-1:0]    instr_addr,
    output logic               res_valid,
    output logic [XLEN-1:0]    eff_addr,
    output logic [XLEN-1:0]    new_base,
    output logic               wb_en,
    output logic [RIDX_W-1:0]  wb_idx,
    output logic               wb_err
);
    logic [XLEN-1:0] base_eff;
    logic            is_pc;
    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] sum;
    logic            want_wb;

    agu_res_t res_d, res_q;

    agu_base_sel #(
        .XLEN(XLEN), .RIDX_W(RIDX_W), .PC_IDX(PC_IDX), .PC_AHEAD(PC_AHEAD)
    ) u_base (
        .base_val  (base_val),
        .base_idx  (base_idx),
        .instr_addr(instr_addr),
        .base_eff  (base_eff),
        .is_pc     (is_pc)
    );

    agu_offset_gen #(
        .XLEN(XLEN), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W)
    ) u_off (
        .use_reg    (use_reg_off),
        .imm        (imm_off),
        .reg_val    (off_reg),
        .shift_right(shift_right),
        .shamt      (shift_amt),
        .offset     (offset)
    );

    agu_addsub #(.XLEN(XLEN)) u_add (
        .a  (base_eff),
        .b  (offset),
        .sub(subtract),
        .y  (sum)
    );

    always_comb begin
        res_d        = res_q;
        res_d.valid  = req_valid;
        res_d.wb_en  = 1'b0;
        res_d.wb_err = 1'b0;
        // post-indexed form always updates the base
        want_wb      = wb_req | post_index;
        if (req_valid) begin
            res_d.eff    = post_index ? base_eff : sum;
            res_d.nbase  = sum;
            res_d.wb_idx = base_idx;
            res_d.wb_en  = want_wb & ~is_pc;
            res_d.wb_err = want_wb & is_pc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid = res_q.valid;
    assign eff_addr  = res_q.eff;
    assign new_base  = res_q.nbase;
    assign wb_en     = res_q.wb_en;
    assign wb_err    = res_q.wb_err;
    assign wb_idx    = res_q.wb_idx;
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 4,
    parameter int PC_IDX = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [XLEN-1:0]   base_val,
    input logic [RIDX_W-1:0] base_idx,
    input logic              post_index,
    input logic              wb_req,
    input logic              res_valid,
    input logic [XLEN-1:0]   eff_addr,
    input logic [XLEN-1:0]   new_base,
    input logic              wb_en,
    input logic [RIDX_W-1:0] wb_idx,
    input logic              wb_err
);
    localparam logic [RIDX_W-1:0] PCI = RIDX_W'(PC_IDX);

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    p_valid_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);
    p_pre_wb_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !post_index) |=> (eff_addr == new_base));
    p_post_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && post_index && base_idx != PCI) |=> (eff_addr == $past(base_val) && wb_en));
    p_pc_refuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && base_idx == PCI && (post_index || wb_req)) |=> (wb_err && !wb_en));
    p_idx_carry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (wb_idx == $past(base_idx)));
    p_idle_strobes_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!wb_en && !wb_err));
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_en && wb_err));
endmodule

bind ls_agu agu_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W), .PC_IDX(PC_IDX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .base_val  (base_val),
    .base_idx  (base_idx),
    .post_index(post_index),
    .wb_req    (wb_req),
    .res_valid (res_valid),
    .eff_addr  (eff_addr),
    .new_base  (new_base),
    .wb_en     (wb_en),
    .wb_idx    (wb_idx),
    .wb_err    (wb_err)
);

// File: tb/ls_agu_tb.sv
module ls_agu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] base_val = '0;
    logic [3:0]  base_idx = '0;
    logic        use_reg_off = 1'b0;
    logic [11:0] imm_off = '0;
    logic [31:0] off_reg = '0;
    logic        shift_right = 1'b0;
    logic [4:0]  shift_amt = '0;
    logic        subtract = 1'b0;
    logic        post_index = 1'b0;
    logic        wb_req = 1'b0;
    logic [31:0] instr_addr = '0;
    logic        res_valid;
    logic [31:0] eff_addr;
    logic [31:0] new_base;
    logic        wb_en;
    logic [3:0]  wb_idx;
    logic        wb_err;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // reference state
    logic        e_valid = 0, e_wben = 0, e_wberr = 0;
    logic [31:0] e_eff = 0, e_nb = 0;
    logic [3:0]  e_idx = 0;
    string       e_tag = "R1";

    always #10 clk = ~clk;

    ls_agu u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_val(base_val),
        .base_idx(base_idx), .use_reg_off(use_reg_off), .imm_off(imm_off),
        .off_reg(off_reg), .shift_right(shift_right), .shift_amt(shift_amt),
        .subtract(subtract), .post_index(post_index), .wb_req(wb_req),
        .instr_addr(instr_addr), .res_valid(res_valid), .eff_addr(eff_addr),
        .new_base(new_base), .wb_en(wb_en), .wb_idx(wb_idx), .wb_err(wb_err)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(e_tag, "res_valid (R2)", 32'(res_valid), 32'(e_valid));
        chk(e_tag, "wb_en", 32'(wb_en), 32'(e_wben));
        chk(e_tag, "wb_err", 32'(wb_err), 32'(e_wberr));
        chk(e_tag, "eff_addr", eff_addr, e_eff);
        chk(e_tag, "new_base", new_base, e_nb);
        chk(e_tag, "wb_idx (R11)", 32'(wb_idx), 32'(e_idx));
    endtask

    // one cycle: check the previous result, then drive and predict the next
    task automatic step(input string tag, input logic rv, input logic [3:0] idx,
                        input logic [31:0] bv, input logic ureg, input logic [11:0] imm,
                        input logic [31:0] orv, input logic sr, input logic [4:0] sa,
                        input logic sub, input logic post, input logic wbr,
                        input logic [31:0] ia);
        logic [31:0] b, o, s;
        logic        want, pc;
        @(negedge clk);
        compare_all();
        req_valid = rv; base_idx = idx; base_val = bv; use_reg_off = ureg;
        imm_off = imm; off_reg = orv; shift_right = sr; shift_amt = sa;
        subtract = sub; post_index = post; wb_req = wbr; instr_addr = ia;
        pc   = (idx == 4'd15);
        b    = pc ? ia + 32'd8 : bv;
        o    = ureg ? (sr ? (orv >> sa) : (orv << sa)) : {20'd0, imm};
        s    = sub ? b - o : b + o;
        want = wbr || post;
        e_tag   = tag;
        e_valid = rv;
        e_wben  = rv && want && !pc;
        e_wberr = rv && want && pc;
        if (rv) begin
            e_eff = post ? b : s;
            e_nb  = s;
            e_idx = idx;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                bad++;
                total++;
                $display("FAIL watchdog expired");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        // R1: reset state while held and just after release
        repeat (3) @(negedge clk);
        chk("R1", "res_valid in reset", 32'(res_valid), 0);
        chk("R1", "wb_en in reset", 32'(wb_en), 0);
        chk("R1", "wb_err in reset", 32'(wb_err), 0);
        rst_n = 1'b1;
        // R3 R6: pre-indexed immediate add, no writeback -> 1052
        step("R3", 1, 4'd2, 32'd1000, 0, 12'd52, 32'hFFFF, 0, 5'd0, 0, 0, 0, 32'd0);
        // R4 R8: push, base 2012 minus 4 with writeback -> 2008/2008
        step("R4", 1, 4'd13, 32'd2012, 0, 12'd4, 32'd0, 0, 5'd0, 1, 0, 1, 32'd0);
        // R5 R7: post-indexed, 25 << 2, wb_req low yet writeback forced
        step("R5", 1, 4'd2, 32'd1000, 1, 12'd0, 32'd25, 0, 5'd2, 0, 1, 0, 32'd0);
        // R7: register offset without shift
        step("R7", 1, 4'd5, 32'd1000, 1, 12'd0, 32'd200, 0, 5'd0, 0, 0, 0, 32'd0);
        // R7 R8: right shift by 31, subtracted
        step("R7", 1, 4'd6, 32'd100, 1, 12'd0, 32'h8000_0000, 1, 5'd31, 1, 0, 1, 32'd0);
        // R7: left shift by 31 drops the high bit
        step("R7", 1, 4'd7, 32'd0, 1, 12'd0, 32'd3, 0, 5'd31, 0, 0, 0, 32'd0);
        // R7: right shift by 2, mixed pattern
        step("R7", 1, 4'd8, 32'h1000, 1, 12'd0, 32'hF0F0_F0F3, 1, 5'd2, 0, 0, 0, 32'd0);
        // R9: program counter base, no writeback -> 1000+8+52
        step("R9", 1, 4'd15, 32'hDEAD_BEEF, 0, 12'd52, 32'd0, 0, 5'd0, 0, 0, 0, 32'd1000);
        // R10: program counter base with writeback request
        step("R10", 1, 4'd15, 32'd0, 0, 12'd16, 32'd0, 0, 5'd0, 1, 0, 1, 32'd2000);
        // R10: program counter base in post-indexed form
        step("R10", 1, 4'd15, 32'd0, 0, 12'd4, 32'd0, 0, 5'd0, 0, 1, 0, 32'd3000);
        // R12: idle cycles with changing inputs, outputs hold
        step("R12", 0, 4'd3, 32'h1234_5678, 1, 12'd9, 32'd7, 1, 5'd3, 1, 1, 1, 32'd40);
        step("R12", 0, 4'd9, 32'h0BAD_F00D, 0, 12'd1, 32'd1, 0, 5'd1, 0, 0, 1, 32'd80);
        // R6 R8: largest immediate subtracted from 0 wraps
        step("R6", 1, 4'd1, 32'd0, 0, 12'hFFF, 32'd0, 0, 5'd0, 1, 0, 0, 32'd0);
        // R5: post-indexed subtract with writeback requested as well
        step("R5", 1, 4'd4, 32'd5000, 0, 12'd100, 32'd0, 0, 5'd0, 1, 1, 1, 32'd0);
        // R11: back-to-back requests with different indices
        step("R11", 1, 4'd14, 32'd64, 1, 12'd0, 32'd1, 0, 5'd4, 0, 0, 1, 32'd0);
        step("R11", 1, 4'd0, 32'd64, 0, 12'd1, 32'd0, 0, 5'd0, 0, 0, 0, 32'd0);
        step("R2", 0, 4'd0, 32'd0, 0, 12'd0, 32'd0, 0, 5'd0, 0, 0, 0, 32'd0);
        @(negedge clk);
        compare_all();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule